// File: doc/BRIEF.md
# Banked GPIO Controller with Edge-Detect Interrupts

This block gathers a parameterised number of general-purpose pins into banks of up to 32 and exposes them through a single-cycle register bus. Software picks each pin's direction, moves output levels high or low through separate set and clear words, reads the synchronised level of every pin, and chooses which transitions (rising, falling or both) are latched into a sticky status word. Status bits are cleared by writing ones.

The bus is combinational on the read side: while `busValid` is high and `busWrite` is low, `busRdata` carries the addressed word in the same cycle. Writes take effect on the rising clock edge that samples them. Pin inputs pass through a two-flop synchroniser, and an edge is the difference between the synchronised value and its copy from one cycle earlier. Pins 0 and 1 each have their own interrupt line. All remaining pins share one interrupt line.

Register words for a bank sit at the bank base plus a type offset. The bank base is `4*n` for banks 0 to 2, and `0x100 + 4*(n-3)` for banks 3 to 5. The type offsets are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Bank n's registers sit at base + type offset, where base is 4*n for n < 3 and 0x100 + 4*(n-3) for n >= 3. The type offsets are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48. Bit k of a bank word belongs to pin 32*n + k.
- R2: A level read returns each pin's input after two synchronising flops. A pin change is not visible after one rising clock edge and is visible after two. This holds regardless of the pin's direction.
- R3: A direction bit of 1 makes the pin an output, which asserts its `padOe` bit. A bit of 0 makes it an input. Direction words read back as written.
- R4: Writing the set word drives `padOut` high for every bit written as 1. Bits written as 0 keep their value.
- R5: Writing the clear word drives `padOut` low for every bit written as 1. Bits written as 0 keep their value.
- R6: A status bit becomes 1 when its pin rises with its rising-enable bit set, or falls with its falling-enable bit set. With both enable bits set, either edge is captured. Enable words read back as written.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing all ones clears the whole bank.
- R8: If a new enabled edge and a clearing write reach the same status bit in the same cycle, the bit remains 1.
- R9: `irqPin0` equals pin 0's status bit and `irqPin1` equals pin 1's status bit. `irqShared` is the OR of the status bits of all other pins.
- R10: In a last bank with fewer than 32 pins, the missing bits read as 0 and writes to them have no effect.
- R11: After reset, all pins are inputs, `padOut` is 0, both enable words are 0, all status bits are 0 and all interrupt lines are low.
- R12: Reads of unmapped or misaligned addresses, and reads of the set and clear words, return 0. Writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle; 0 when not reading |
| pinIn | input | NUM_PINS | Asynchronous pin levels |
| padOut | output | NUM_PINS | Output level per pin |
| padOe | output | NUM_PINS | Output enable per pin |
| irqPin0 | output | 1 | Status of pin 0 |
| irqPin1 | output | 1 | Status of pin 1 |
| irqShared | output | 1 | OR of status of pins 2 and up |

## Verification
On every cycle, the assertions check the following:
- `padOut` and `padOe` move only in the cycle after a bus write.
- `irqPin0` falls only after a clearing write to bank 0 with bit 0 set.
- `irqPin0` rises only after the synchronised level of pin 0 has changed.
- An unmapped read returns zero.

The bench scenarios show the rest, since they depend on data values and address arithmetic:
- that the address map reaches every bank, including the jump past bank 2;
- that the enable masks choose the right edges;
- that a clear colliding with a new edge loses;
- that the short last bank masks its missing bits.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    REG_LEVEL = 3'd0,
    REG_DIR   = 3'd1,
    REG_SET   = 3'd2,
    REG_CLR   = 3'd3,
    REG_RISE  = 3'd4,
    REG_FALL  = 3'd5,
    REG_STAT  = 3'd6
  } regKind_t;

  // Strobes from address decode to the datapath.
  typedef struct packed {
    logic     hit;
    logic     wr;
    logic [2:0] bank;
    regKind_t kind;
  } busStrobe_t;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  localparam int unsigned TYPE_STRIDE = 12;
  localparam int unsigned NUM_KINDS   = 7;
  localparam logic [31:0] HIGH_BASE   = 32'h100;
  localparam logic [31:0] ADDR_LIMIT  = 32'h200;
  localparam int unsigned LOW_BANKS   = 3;

  logic [31:0] addrU, offU, kindU, slotU, bankU;
  logic        upper;

  always_comb begin
    addrU = 32'(busAddr);
    upper = addrU >= HIGH_BASE;
    offU  = upper ? addrU - HIGH_BASE : addrU;
    kindU = offU / TYPE_STRIDE;
    slotU = (offU % TYPE_STRIDE) / 4;
    bankU = slotU + (upper ? 32'(LOW_BANKS) : 32'd0);
    strobe.hit  = busValid && (addrU < ADDR_LIMIT) && (offU[1:0] == 2'b00)
                  && (kindU < NUM_KINDS) && (bankU < NUM_BANKS);
    strobe.wr   = busWrite;
    strobe.bank = bankU[2:0];
    strobe.kind = regKind_t'(kindU[2:0]);
  end
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 100,
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strobe,
  input  logic [WORD_W-1:0]   busWdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [WORD_W-1:0]   busRdata,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] levelSync,
  output logic [NUM_PINS-1:0] edgeStat
);
  localparam int unsigned PAD_W = NUM_BANKS * WORD_W;

  logic [NUM_PINS-1:0] syncA, syncB, prevB;
  logic [NUM_PINS-1:0] dirQ, outQ, riseQ, fallQ, statQ;
  logic [NUM_PINS-1:0] bankWrMask, wdataSpread, wrBits, edgeNow;
  logic                isDir, isSet, isClr, isRise, isFall, isStat;

  // Spread the bus word across the pins of the addressed bank.
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign bankWrMask[i]  = strobe.hit && strobe.wr && (strobe.bank == 3'(i / WORD_W));
    assign wdataSpread[i] = busWdata[i % WORD_W];
  end

  assign wrBits = bankWrMask & wdataSpread;
  assign isDir  = strobe.kind == REG_DIR;
  assign isSet  = strobe.kind == REG_SET;
  assign isClr  = strobe.kind == REG_CLR;
  assign isRise = strobe.kind == REG_RISE;
  assign isFall = strobe.kind == REG_FALL;
  assign isStat = strobe.kind == REG_STAT;

  assign edgeNow = (riseQ & syncB & ~prevB) | (fallQ & ~syncB & prevB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
      dirQ  <= '0;
      outQ  <= '0;
      riseQ <= '0;
      fallQ <= '0;
      statQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
      if (isDir)  dirQ  <= (dirQ  & ~bankWrMask) | (wdataSpread & bankWrMask);
      if (isRise) riseQ <= (riseQ & ~bankWrMask) | (wdataSpread & bankWrMask);
      if (isFall) fallQ <= (fallQ & ~bankWrMask) | (wdataSpread & bankWrMask);
      if (isSet)  outQ  <= outQ | wrBits;
      else if (isClr) outQ <= outQ & ~wrBits;
      // A fresh edge wins over a clearing write in the same cycle.
      statQ <= (statQ & ~(isStat ? wrBits : '0)) | edgeNow;
    end
  end

  // Zero-extended copies, so words of a short last bank read zero on missing bits.
  logic [PAD_W-1:0] lvlPad, dirPad, risePad, fallPad, statPad;
  assign lvlPad  = PAD_W'(syncB);
  assign dirPad  = PAD_W'(dirQ);
  assign risePad = PAD_W'(riseQ);
  assign fallPad = PAD_W'(fallQ);
  assign statPad = PAD_W'(statQ);

  always_comb begin
    busRdata = '0;
    if (strobe.hit && !strobe.wr) begin
      for (int b = 0; b < int'(NUM_BANKS); b++) begin
        if (strobe.bank == 3'(b)) begin
          case (strobe.kind)
            REG_LEVEL: busRdata = lvlPad[b*WORD_W +: WORD_W];
            REG_DIR:   busRdata = dirPad[b*WORD_W +: WORD_W];
            REG_RISE:  busRdata = risePad[b*WORD_W +: WORD_W];
            REG_FALL:  busRdata = fallPad[b*WORD_W +: WORD_W];
            REG_STAT:  busRdata = statPad[b*WORD_W +: WORD_W];
            default:   busRdata = '0;
          endcase
        end
      end
    end
  end

  assign padOut    = outQ;
  assign padOe     = dirQ;
  assign levelSync = syncB;
  assign edgeStat  = statQ;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int unsigned NUM_PINS = 100
) (
  input  logic [NUM_PINS-1:0] edgeStat,
  output logic                irqPin0,
  output logic                irqPin1,
  output logic                irqShared
);
  assign irqPin0   = edgeStat[0];
  assign irqPin1   = edgeStat[1];
  assign irqShared = |edgeStat[NUM_PINS-1:2];
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned NUM_PINS = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqPin0,
  output logic                irqPin1,
  output logic                irqShared
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;

  busStrobe_t          strobe;
  logic [NUM_PINS-1:0] levelSync;
  logic [NUM_PINS-1:0] edgeStat;

  gpio_bank_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) decode_i (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .strobe(strobe)
  );

  gpio_bank_datapath #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata), .pinIn(pinIn),
    .busRdata(busRdata), .padOut(padOut), .padOe(padOe),
    .levelSync(levelSync), .edgeStat(edgeStat)
  );

  gpio_bank_irq #(.NUM_PINS(NUM_PINS)) irq_i (
    .edgeStat(edgeStat), .irqPin0(irqPin0), .irqPin1(irqPin1), .irqShared(irqShared)
  );
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned NUM_PINS = 100
) (
  input logic                clk,
  input logic                rstN,
  input logic                busValid,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busWdata,
  input logic [31:0]         busRdata,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic                irqPin0,
  input logic                levelSync0
);
  localparam logic [ADDR_W-1:0] STAT0_ADDR = ADDR_W'(12'h048);
  localparam logic [ADDR_W-1:0] HOLE_ADDR  = ADDR_W'(12'h054);

  // R3
  a_r3_oe_moves_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(padOe) |-> $past(busValid && busWrite));

  // R4, R5
  a_r4_out_moves_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(padOut) |-> $past(busValid && busWrite));

  // R7
  a_r7_irq0_drop_needs_w1c: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqPin0) |-> $past(busValid && busWrite && busAddr == STAT0_ADDR && busWdata[0]));

  // R6
  a_r6_irq0_rise_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPin0) |-> ($past(levelSync0) != $past(levelSync0, 2)));

  // R12
  a_r12_hole_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == HOLE_ADDR) |-> busRdata == 32'd0);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .padOut(padOut), .padOe(padOe), .irqPin0(irqPin0), .levelSync0(levelSync[0])
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int NP = 100;
  localparam int NB = (NP + 31) / 32;
  localparam int K_LVL = 0, K_DIR = 1, K_SET = 2, K_CLR = 3, K_RISE = 4, K_FALL = 5, K_STAT = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0, busRdata;
  logic [NP-1:0] pinIn = '0, padOut, padOe;
  logic          irqPin0, irqPin1, irqShared;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [NP-1:0] mDir = '0, mOut = '0, mRise = '0, mFall = '0, mStat = '0, mPin = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl #(.ADDR_W(AW), .NUM_PINS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .padOut(padOut), .padOe(padOe),
    .irqPin0(irqPin0), .irqPin1(irqPin1), .irqShared(irqShared)
  );

  function automatic logic [AW-1:0] addrOf(int b, int k);
    int base = (b < 3) ? b * 4 : 'h100 + (b - 3) * 4;
    return AW'(base + k * 12);
  endfunction

  function automatic logic [31:0] wordOf(logic [NP-1:0] v, int b);
    logic [NB*32-1:0] p = '0;
    p[NP-1:0] = v;
    return p[b*32 +: 32];
  endfunction

  function automatic logic [NP-1:0] putWord(logic [NP-1:0] v, int b, logic [31:0] w, logic [31:0] en);
    for (int k = 0; k < 32; k++)
      if (b * 32 + k < NP && en[k]) v[b*32+k] = w[k];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrAddr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdAddr(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic chkPads(string tag);
    for (int b = 0; b < NB; b++) begin
      chk({tag, " padOut"}, wordOf(padOut, b), wordOf(mOut, b));
      chk({tag, " padOe"}, wordOf(padOe, b), wordOf(mDir, b));
    end
  endtask

  task automatic chkWords(string tag, int k, logic [NP-1:0] m);
    logic [31:0] r;
    for (int b = 0; b < NB; b++) begin
      rdAddr(addrOf(b, k), r);
      chk(tag, r, wordOf(m, b));
    end
  endtask

  task automatic chkIrq(string tag);
    chk({tag, " irqPin0"}, 32'(irqPin0), 32'(mStat[0]));
    chk({tag, " irqPin1"}, 32'(irqPin1), 32'(mStat[1]));
    chk({tag, " irqShared"}, 32'(irqShared), 32'(|mStat[NP-1:2]));
  endtask

  // Drive new pin levels, update the edge model, allow the synchroniser to settle.
  task automatic applyPins(logic [NP-1:0] v);
    @(negedge clk);
    mStat = mStat | (mRise & v & ~mPin) | (mFall & ~v & mPin);
    mPin  = v;
    pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, p;
    logic [NP-1:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset state at the ports and in every register word.
    chkPads("R11 reset");
    chkIrq("R11 reset");
    for (int k = 0; k < 7; k++) chkWords("R11 reset word", k, '0);

    // R3, R1, R10: direction sweep across every bank (bank 3 sits past the 0x100 jump).
    for (int b = 0; b < NB; b++) begin
      p = 32'hA5C3_0F96 ^ (32'h1111_1111 * b);
      wrAddr(addrOf(b, K_DIR), p);
      mDir = putWord(mDir, b, p, '1);
    end
    chkWords("R1 R3 R10 direction readback", K_DIR, mDir);
    chkPads("R3 direction");

    // R4, R5: set and clear words, including zero words that must change nothing.
    for (int b = 0; b < NB; b++) begin
      p = 32'h0F0F_3C3C ^ (32'h0101_0101 << b);
      wrAddr(addrOf(b, K_SET), p);
      mOut = putWord(mOut, b, '1, p);
    end
    chkPads("R4 set");
    for (int b = 0; b < NB; b++) begin
      p = 32'h3333_0F00 >> b;
      wrAddr(addrOf(b, K_CLR), p);
      mOut = putWord(mOut, b, '0, p);
    end
    chkPads("R5 clear");
    for (int b = 0; b < NB; b++) begin
      wrAddr(addrOf(b, K_SET), '0);
      wrAddr(addrOf(b, K_CLR), '0);
    end
    chkPads("R4 R5 zero words");
    chkWords("R12 set word reads zero", K_SET, '0);
    chkWords("R12 clear word reads zero", K_CLR, '0);

    // R2: synchroniser latency on bank 0.
    @(negedge clk);
    pinIn[5] = 1'b1; mPin[5] = 1'b1;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = addrOf(0, K_LVL);
    #1 chk("R2 level after one edge", busRdata & 32'h20, 32'h0);
    @(negedge clk);
    #1 chk("R2 level after two edges", busRdata & 32'h20, 32'h20);
    busValid = 1'b0;

    // R2: level readback under several patterns, independent of direction.
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < NP; i++) begin
        case (t)
          0: v[i] = 1'b1;
          1: v[i] = i[0];
          2: v[i] = (i % 3) == 0;
          3: v[i] = 1'b0;
          4: v[i] = (i % 7) == 2;
          default: v[i] = ~i[1];
        endcase
      end
      applyPins(v);
      chkWords("R2 level pattern", K_LVL, mPin);
    end
    applyPins('0);

    // R6: enable masks. Rising on i%3==0, falling on i%3==1, both on i%3==2.
    for (int i = 0; i < NP; i++) begin
      mRise[i] = (i % 3) != 1;
      mFall[i] = (i % 3) != 0;
    end
    for (int b = 0; b < NB; b++) begin
      wrAddr(addrOf(b, K_RISE), wordOf(mRise, b) | 32'hFFFF_FFF0 * (b == NB - 1));
      wrAddr(addrOf(b, K_FALL), wordOf(mFall, b));
    end
    chkWords("R6 R10 rise enable readback", K_RISE, mRise);
    chkWords("R6 fall enable readback", K_FALL, mFall);
    chkWords("R6 no status yet", K_STAT, '0);

    applyPins('1);
    chkWords("R6 rising capture", K_STAT, mStat);
    chkIrq("R9 after rise");

    // R7: clear everything.
    for (int b = 0; b < NB; b++) wrAddr(addrOf(b, K_STAT), '1);
    mStat = '0;
    chkWords("R7 clear all", K_STAT, mStat);
    chkIrq("R9 after clear");

    applyPins('0);
    chkWords("R6 falling capture", K_STAT, mStat);
    chkIrq("R9 after fall");

    // R7: partial clear and a zero write.
    wrAddr(addrOf(0, K_STAT), 32'h0000_FFFF);
    mStat = putWord(mStat, 0, '0, 32'h0000_FFFF);
    wrAddr(addrOf(1, K_STAT), 32'h0);
    chkWords("R7 partial and zero clear", K_STAT, mStat);
    chkIrq("R9 shared only");

    // R9: only pin 1 pending.
    for (int b = 0; b < NB; b++) wrAddr(addrOf(b, K_STAT), '1);
    mStat = '0;
    v = '0; v[1] = 1'b1;
    applyPins(v);
    applyPins('0);
    chkIrq("R9 pin1 alone");
    wrAddr(addrOf(0, K_STAT), 32'h2);
    mStat = '0;
    chkIrq("R9 pin1 cleared");

    // R8: pin 0 status set, then a new rising edge meets a clearing write.
    v = '0; v[0] = 1'b1;
    applyPins(v);
    applyPins('0);
    chk("R8 pin0 pending", 32'(irqPin0), 32'd1);
    @(negedge clk);
    pinIn[0] = 1'b1; mPin[0] = 1'b1;
    @(negedge clk);
    wrAddr(addrOf(0, K_STAT), 32'h1);
    rdAddr(addrOf(0, K_STAT), r);
    chk("R8 edge beats clear", r & 32'h1, 32'h1);
    chk("R8 irqPin0 held", 32'(irqPin0), 32'd1);
    wrAddr(addrOf(0, K_STAT), 32'h1);
    mStat[0] = 1'b0;
    chk("R7 later clear works", 32'(irqPin0), 32'd0);

    // R12: unmapped and misaligned reads, ignored unmapped writes.
    rdAddr(AW'('h054), r); chk("R12 hole 0x054", r, 0);
    rdAddr(AW'('h002), r); chk("R12 misaligned 0x002", r, 0);
    rdAddr(AW'('h0FC), r); chk("R12 hole 0x0FC", r, 0);
    rdAddr(AW'('h104), r); chk("R12 absent bank 4", r, 0);
    rdAddr(AW'('h200), r); chk("R12 beyond map", r, 0);
    rdAddr(AW'('h3FF), r); chk("R12 top address", r, 0);
    wrAddr(AW'('h110), '1);
    wrAddr(AW'('h210), '1);
    wrAddr(AW'('h00E), '1);
    chkWords("R12 directions untouched", K_DIR, mDir);
    chkPads("R12 pads untouched");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule